// File: doc/BRIEF.md
# Interrupt Controller Command Register Interface

This block is the command and status front end of an eight-line interrupt controller. It sits on a byte-wide bus with one address bit, a write strobe and a read strobe. Software uses it to start a configuration sequence, to program the vector base, the line mask and the operating options, and to issue end-of-interrupt and priority-rotation commands. The block holds the pending-request (IRR), in-service (ISR) and mask (IMR) registers. It drives the settings that an external priority resolver needs: vector base, rotation base, automatic end of interrupt, nested mode and special mask. When the resolver grants a line, it reports this on a grant port.

An address-0 write with bit 4 set starts configuration. The next address-1 writes then supply the vector base, a cascade word that is ignored, and an optional options word. Other address-0 writes are either status/poll commands (bit 3 set) or end-of-interrupt and rotation commands (bits 4 and 3 clear). A poll read returns the best pending line with bit 7 set and retires that line in the same access. Every write takes effect on the clock edge that samples its strobe. State and status outputs are registered. Read data is combinational from the current state.

Top module: `icc_regif`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, all registers and outputs read zero and no configuration is in progress.
- R2: An address-0 write with data bit 4 set starts configuration. It records data bit 0 as "options word expected", clears IMR, the rotation base, the special mask, the read select and the stored input levels, and zeroes IRR for edge lines. If bit 0 is 0 it also clears automatic EOI and nested mode.
- R3: During configuration, each address-1 write advances a sequence: the first sets `vec_base` to data AND 0xF8, the second is ignored, and the third (sent only if an options word was requested) ends the sequence. No address-1 write in the sequence alters IMR. `init_busy` is high until the sequence ends.
- R4: The options word sets `nested_mode` from data bit 4 and `auto_eoi` from data bit 1.
- R5: An address-1 write outside configuration loads IMR with the data byte.
- R6: An address-0 write with bit 4 clear and bit 3 set does three things: data bit 2 arms a poll; when data bit 1 is set, data bit 0 selects ISR (1) or IRR (0) for reads; when data bit 6 is set, data bit 5 sets the special mask.
- R7: Command code 1 (address 0, bits 4:3 = 0, bits 7:5 = 001) clears the highest-priority ISR bit. Priority starts at the line numbered `rot_base` and rises in number with wrap. The command has no effect when ISR is empty.
- R8: In command codes (bits 7:5), code 5 acts as code 1 and also sets `rot_base` to (cleared line + 1) mod 8. Code 3 clears ISR bit data[2:0]. Code 7 clears that bit and sets `rot_base` to (data[2:0] + 1) mod 8. Code 6 sets `rot_base` to (data[2:0] + 1) mod 8. Codes 0 and 4 set `rot_on_aeoi` to data bit 7. Code 2 changes nothing.
- R9: A line with `lvl_mode` set has its IRR bit follow `irq_in` one cycle later. An edge line sets its IRR bit on a 0-to-1 change between consecutive samples, and the bit holds until a grant or a poll clears it.
- R10: A grant sets the granted ISR bit, unless automatic EOI is on, and clears the IRR bit of an edge line. With automatic EOI and `rot_on_aeoi` both on, a grant sets `rot_base` to (line + 1) mod 8; a rotation command in the same cycle takes precedence.
- R11: A read while a poll is armed returns 0x80 OR the best unmasked pending line when that line outranks every in-service line, and then clears that line in IRR and ISR. Otherwise it returns 0x07. Either way the poll is disarmed after the read.
- R12: A normal read returns IMR at address 1, and ISR or IRR at address 0 according to the read select. With no read, or with a write in the same cycle, `bus_rdata` is 0 and the read has no effect.
- R13: Each ISR clear caused by a command or a poll pulses `eoi_vld` for one cycle, with the line on `eoi_id`, in the cycle after the strobe.
- R14: When a grant and an end-of-interrupt command fall in the same cycle, the command selects its line from the ISR held before that cycle. If both touch the same bit, the set from the grant wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register address bit |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| irq_in | input | 8 | Request inputs |
| lvl_mode | input | 8 | Per-line level (1) or edge (0) sensing |
| grant_vld | input | 1 | Resolver grants a line this cycle |
| grant_id | input | 3 | Granted line |
| irr_o | output | 8 | Pending requests |
| isr_o | output | 8 | In-service lines |
| imr_o | output | 8 | Line mask |
| vec_base | output | 8 | Vector base, low three bits zero |
| rot_base | output | 3 | Line that currently holds the highest priority |
| auto_eoi | output | 1 | Automatic end of interrupt on |
| rot_on_aeoi | output | 1 | Rotate on automatic end of interrupt |
| nested_mode | output | 1 | Special nested mode |
| special_mask | output | 1 | Special mask mode |
| poll_armed | output | 1 | Next read is a poll |
| read_isr | output | 1 | Normal address-0 read returns ISR |
| init_busy | output | 1 | Configuration sequence in progress |
| eoi_vld | output | 1 | An ISR bit was cleared by command or poll |
| eoi_id | output | 3 | Line cleared |

## Verification
A resolver grant and an end-of-interrupt write can land on the same clock edge. One of them sets an ISR bit and the other clears one. The bench provokes this by driving a grant for line 4 together with a specific EOI for line 4. It checks that the bit stays set and that `eoi_vld` still reports line 4. A long random phase also mixes grants, commands, polls and configuration writes freely. In that phase a behavioural model, updated on every edge, checks which ISR, IRR and rotation-base values result from each collision.

// File: rtl/icc_pkg.sv
package icc_pkg;
   localparam int ICC_LINES = 8;
   localparam int ICC_IDW   = 3;

   typedef enum logic [1:0] {
      PH_RUN = 2'd0,
      PH_W2  = 2'd1,
      PH_W3  = 2'd2,
      PH_W4  = 2'd3
   } phase_t;

   typedef struct packed {
      logic                hit;
      logic [ICC_IDW-1:0]  rank;
      logic [ICC_IDW-1:0]  line;
   } pick_t;

   // first set bit walking upward from base, with wrap
   function automatic pick_t rot_pick(input logic [ICC_LINES-1:0] m,
                                      input logic [ICC_IDW-1:0] base);
      pick_t p;
      p = '0;
      for (int k = ICC_LINES - 1; k >= 0; k--) begin
         if (m[base + ICC_IDW'(k)]) begin
            p.hit  = 1'b1;
            p.rank = ICC_IDW'(k);
            p.line = base + ICC_IDW'(k);
         end
      end
      return p;
   endfunction
endpackage

// File: rtl/icc_init_seq.sv
module icc_init_seq
   import icc_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          addr,
   input  logic [DW-1:0] wdata,
   output logic          init_go,
   output logic          busy,
   output logic [DW-1:0] vec_base,
   output logic          nested,
   output logic          aeoi,
   output logic [DW-1:0] imr
);
   localparam logic [DW-1:0] VEC_MASK = ~DW'(7);

   phase_t ph;
   logic   need4;

   assign init_go = wr_en & ~addr & wdata[4];
   assign busy    = (ph != PH_RUN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph       <= PH_RUN;
         need4    <= 1'b0;
         vec_base <= '0;
         nested   <= 1'b0;
         aeoi     <= 1'b0;
         imr      <= '0;
      end else if (init_go) begin
         need4 <= wdata[0];
         imr   <= '0;
         if (!wdata[0]) begin
            nested <= 1'b0;
            aeoi   <= 1'b0;
         end
         ph <= PH_W2;
      end else if (wr_en && addr) begin
         unique case (ph)
            PH_RUN: imr <= wdata;
            PH_W2: begin
               vec_base <= wdata & VEC_MASK;
               ph       <= PH_W3;
            end
            PH_W3: ph <= need4 ? PH_W4 : PH_RUN;
            PH_W4: begin
               nested <= wdata[4];
               aeoi   <= wdata[1];
               ph     <= PH_RUN;
            end
            default: ph <= PH_RUN;
         endcase
      end
   end
endmodule

// File: rtl/icc_ocw.sv
module icc_ocw
   import icc_pkg::*;
#(
   parameter int N   = 8,
   parameter int IDW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           addr,
   input  logic [7:0]     wdata,
   input  logic           init_go,
   input  logic [N-1:0]   isr,
   input  logic           grant_vld,
   input  logic [IDW-1:0] grant_id,
   input  logic           aeoi,
   input  logic           poll_rd,
   input  logic           poll_hit,
   input  logic [IDW-1:0] poll_line,
   output logic [IDW-1:0] rot_base,
   output logic           rot_aeoi,
   output logic           smm,
   output logic           rsel,
   output logic           poll_armed,
   output logic [N-1:0]   isr_clr,
   output logic           eoi_vld,
   output logic [IDW-1:0] eoi_id
);
   logic           cmd_wr, ocw3_wr;
   logic [2:0]     code;
   pick_t          top_isr;
   logic           clr_v, base_ld;
   logic [IDW-1:0] clr_id, base_nx;

   assign cmd_wr  = wr_en & ~addr & ~wdata[4] & ~wdata[3];
   assign ocw3_wr = wr_en & ~addr & ~wdata[4] &  wdata[3];
   assign code    = wdata[7:5];
   assign top_isr = rot_pick(isr, rot_base);

   always_comb begin
      clr_v   = 1'b0;
      clr_id  = '0;
      base_ld = 1'b0;
      base_nx = '0;
      if (cmd_wr) begin
         unique case (code)
            3'd1, 3'd5: begin
               if (top_isr.hit) begin
                  clr_v  = 1'b1;
                  clr_id = top_isr.line;
                  if (code == 3'd5) begin
                     base_ld = 1'b1;
                     base_nx = top_isr.line + IDW'(1);
                  end
               end
            end
            3'd3: begin
               clr_v  = 1'b1;
               clr_id = wdata[IDW-1:0];
            end
            3'd6: begin
               base_ld = 1'b1;
               base_nx = wdata[IDW-1:0] + IDW'(1);
            end
            3'd7: begin
               clr_v   = 1'b1;
               clr_id  = wdata[IDW-1:0];
               base_ld = 1'b1;
               base_nx = wdata[IDW-1:0] + IDW'(1);
            end
            default: ;
         endcase
      end else if (poll_rd && poll_hit) begin
         clr_v  = 1'b1;
         clr_id = poll_line;
      end
   end

   assign isr_clr = clr_v ? (N'(1) << clr_id) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rot_base   <= '0;
         rot_aeoi   <= 1'b0;
         smm        <= 1'b0;
         rsel       <= 1'b0;
         poll_armed <= 1'b0;
         eoi_vld    <= 1'b0;
         eoi_id     <= '0;
      end else begin
         eoi_vld <= clr_v;
         eoi_id  <= clr_id;
         if (init_go)
            rot_base <= '0;
         else if (base_ld)
            rot_base <= base_nx;
         else if (grant_vld && aeoi && rot_aeoi)
            rot_base <= grant_id + IDW'(1);
         if (cmd_wr && (code == 3'd0 || code == 3'd4))
            rot_aeoi <= wdata[7];
         if (init_go) begin
            smm  <= 1'b0;
            rsel <= 1'b0;
         end else if (ocw3_wr) begin
            if (wdata[1]) rsel <= wdata[0];
            if (wdata[6]) smm  <= wdata[5];
         end
         if (ocw3_wr && wdata[2])
            poll_armed <= 1'b1;
         else if (poll_rd)
            poll_armed <= 1'b0;
      end
   end
endmodule

// File: rtl/icc_line_bank.sv
module icc_line_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic [N-1:0] lvl_mode,
   input  logic         init_go,
   input  logic [N-1:0] irr_clr,
   input  logic [N-1:0] isr_clr,
   input  logic [N-1:0] isr_set,
   output logic [N-1:0] irr,
   output logic [N-1:0] isr
);
   logic [N-1:0] prev;

   for (genvar g = 0; g < N; g++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irr[g]  <= 1'b0;
            isr[g]  <= 1'b0;
            prev[g] <= 1'b0;
         end else begin
            prev[g] <= init_go ? 1'b0 : irq_in[g];
            if (lvl_mode[g])
               irr[g] <= irq_in[g];
            else if (init_go)
               irr[g] <= 1'b0;
            else
               irr[g] <= (irr[g] & ~irr_clr[g]) | (irq_in[g] & ~prev[g]);
            isr[g] <= (isr[g] & ~isr_clr[g]) | isr_set[g];
         end
      end
   end
endmodule

// File: rtl/icc_regif.sv
module icc_regif
   import icc_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int N_LINES = 8,
   localparam int ID_W   = $clog2(N_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [N_LINES-1:0] irq_in,
   input  logic [N_LINES-1:0] lvl_mode,
   input  logic              grant_vld,
   input  logic [ID_W-1:0]   grant_id,
   output logic [N_LINES-1:0] irr_o,
   output logic [N_LINES-1:0] isr_o,
   output logic [N_LINES-1:0] imr_o,
   output logic [DATA_W-1:0] vec_base,
   output logic [ID_W-1:0]   rot_base,
   output logic              auto_eoi,
   output logic              rot_on_aeoi,
   output logic              nested_mode,
   output logic              special_mask,
   output logic              poll_armed,
   output logic              read_isr,
   output logic              init_busy,
   output logic              eoi_vld,
   output logic [ID_W-1:0]   eoi_id
);
   if (DATA_W != 8 || N_LINES != ICC_LINES || ID_W != ICC_IDW) begin : g_bad_cfg
      $error("icc_regif: command encodings need an 8-bit bus and 8 lines");
   end

   logic               init_go, rd_fire, poll_rd, poll_hit;
   logic [N_LINES-1:0] isr_clr, irr_clr, isr_set, grant_mask, poll_mask;
   pick_t              pend_pick, serv_pick;
   logic [DATA_W-1:0]  poll_byte;

   icc_init_seq #(.DW(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bus_wr),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .init_go  (init_go),
      .busy     (init_busy),
      .vec_base (vec_base),
      .nested   (nested_mode),
      .aeoi     (auto_eoi),
      .imr      (imr_o)
   );

   // poll evaluation on the state held before this edge
   assign pend_pick = rot_pick(irr_o & ~imr_o, rot_base);
   assign serv_pick = rot_pick(isr_o, rot_base);
   assign poll_hit  = pend_pick.hit & (~serv_pick.hit | (pend_pick.rank < serv_pick.rank));
   assign poll_byte = poll_hit ? {1'b1, {(DATA_W-1-ID_W){1'b0}}, pend_pick.line} : DATA_W'(7);
   assign rd_fire   = bus_rd & ~bus_wr;
   assign poll_rd   = rd_fire & poll_armed;

   icc_ocw #(.N(N_LINES), .IDW(ID_W)) u_ocw (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bus_wr),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .init_go    (init_go),
      .isr        (isr_o),
      .grant_vld  (grant_vld),
      .grant_id   (grant_id),
      .aeoi       (auto_eoi),
      .poll_rd    (poll_rd),
      .poll_hit   (poll_hit),
      .poll_line  (pend_pick.line),
      .rot_base   (rot_base),
      .rot_aeoi   (rot_on_aeoi),
      .smm        (special_mask),
      .rsel       (read_isr),
      .poll_armed (poll_armed),
      .isr_clr    (isr_clr),
      .eoi_vld    (eoi_vld),
      .eoi_id     (eoi_id)
   );

   assign grant_mask = grant_vld ? (N_LINES'(1) << grant_id) : '0;
   assign poll_mask  = (poll_rd && poll_hit) ? (N_LINES'(1) << pend_pick.line) : '0;
   assign irr_clr    = (grant_mask & ~lvl_mode) | poll_mask;
   assign isr_set    = auto_eoi ? '0 : grant_mask;

   icc_line_bank #(.N(N_LINES)) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .lvl_mode (lvl_mode),
      .init_go  (init_go),
      .irr_clr  (irr_clr),
      .isr_clr  (isr_clr),
      .isr_set  (isr_set),
      .irr      (irr_o),
      .isr      (isr_o)
   );

   always_comb begin
      if (!rd_fire)
         bus_rdata = '0;
      else if (poll_armed)
         bus_rdata = poll_byte;
      else if (bus_addr)
         bus_rdata = imr_o;
      else
         bus_rdata = read_isr ? isr_o : irr_o;
   end
endmodule

// File: rtl/icc_regif_chk.sv
module icc_regif_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_addr,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic [7:0] bus_wdata,
   input logic [7:0] irq_in,
   input logic [7:0] lvl_mode,
   input logic       grant_vld,
   input logic [7:0] irr_o,
   input logic [7:0] isr_o,
   input logic [7:0] imr_o,
   input logic [2:0] rot_base,
   input logic       poll_armed,
   input logic       init_busy,
   input logic       eoi_vld,
   input logic [2:0] eoi_id
);
   // R5
   imr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr && !init_busy) |=> imr_o == $past(bus_wdata));

   // R3
   init_imr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr && init_busy) |=> $stable(imr_o));

   // R2
   init_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && bus_wdata[4]) |=> (imr_o == 8'h00 && init_busy && rot_base == 3'd0));

   // R11
   poll_oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && poll_armed) |=> !poll_armed);

   // R9
   level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((irr_o ^ $past(irq_in)) & $past(lvl_mode)) == 8'h00);

   // R7
   eoi_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_addr && bus_wdata == 8'h20 && isr_o == 8'h00 && !grant_vld)
      |=> (isr_o == 8'h00 && !eoi_vld));

   // R13
   eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_vld && !$past(grant_vld)) |-> !isr_o[eoi_id]);
endmodule

bind icc_regif icc_regif_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_wdata  (bus_wdata),
   .irq_in     (irq_in),
   .lvl_mode   (lvl_mode),
   .grant_vld  (grant_vld),
   .irr_o      (irr_o),
   .isr_o      (isr_o),
   .imr_o      (imr_o),
   .rot_base   (rot_base),
   .poll_armed (poll_armed),
   .init_busy  (init_busy),
   .eoi_vld    (eoi_vld),
   .eoi_id     (eoi_id)
);

// File: tb/icc_regif_test.sv
module icc_regif_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_addr, bus_wr, bus_rd;
   logic [7:0] bus_wdata, bus_rdata;
   logic [7:0] irq_in, lvl_mode;
   logic       grant_vld;
   logic [2:0] grant_id;
   logic [7:0] irr_o, isr_o, imr_o, vec_base;
   logic [2:0] rot_base, eoi_id;
   logic       auto_eoi, rot_on_aeoi, nested_mode, special_mask;
   logic       poll_armed, read_isr, init_busy, eoi_vld;

   always #10 clk = ~clk;

   icc_regif uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .lvl_mode(lvl_mode),
      .grant_vld(grant_vld), .grant_id(grant_id), .irr_o(irr_o), .isr_o(isr_o),
      .imr_o(imr_o), .vec_base(vec_base), .rot_base(rot_base), .auto_eoi(auto_eoi),
      .rot_on_aeoi(rot_on_aeoi), .nested_mode(nested_mode), .special_mask(special_mask),
      .poll_armed(poll_armed), .read_isr(read_isr), .init_busy(init_busy),
      .eoi_vld(eoi_vld), .eoi_id(eoi_id)
   );

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference ----------------
   logic [7:0] m_irr, m_isr, m_imr, m_prev, m_vec;
   int         m_ph, m_rb, m_eoid;
   bit         m_need4, m_nest, m_aeoi, m_raeoi, m_smm, m_rsel, m_poll, m_eoiv;

   function automatic int rank_of(input logic [7:0] m, input int b);
      for (int k = 0; k < 8; k++)
         if (m[(b + k) % 8]) return k;
      return 8;
   endfunction

   function automatic logic [7:0] m_poll_byte();
      int pr, cr;
      pr = rank_of(m_irr & ~m_imr, m_rb);
      cr = rank_of(m_isr, m_rb);
      if (pr < 8 && pr < cr) return 8'h80 | 8'((m_rb + pr) % 8);
      return 8'h07;
   endfunction

   function automatic logic [7:0] m_rdata();
      if (!(bus_rd && !bus_wr)) return 8'h00;
      if (m_poll) return m_poll_byte();
      if (bus_addr) return m_imr;
      return m_rsel ? m_isr : m_irr;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_irr = 0; m_isr = 0; m_imr = 0; m_prev = 0; m_vec = 0;
         m_ph = 0; m_rb = 0; m_eoid = 0; m_need4 = 0; m_nest = 0; m_aeoi = 0;
         m_raeoi = 0; m_smm = 0; m_rsel = 0; m_poll = 0; m_eoiv = 0;
      end else begin
         logic [7:0] clr_i, clr_r, set_i;
         bit init, base_cmd, o_aeoi, o_raeoi;
         int r, ln, code;
         clr_i = 0; clr_r = 0; set_i = 0; init = 0; base_cmd = 0;
         o_aeoi = m_aeoi; o_raeoi = m_raeoi;
         m_eoiv = 0;
         if (bus_wr && !bus_addr && bus_wdata[4]) begin
            init = 1; m_need4 = bus_wdata[0]; m_imr = 0; m_rb = 0; m_smm = 0; m_rsel = 0;
            if (!bus_wdata[0]) begin m_nest = 0; m_aeoi = 0; end
            m_ph = 1;
         end else if (bus_wr && !bus_addr && bus_wdata[3]) begin
            if (bus_wdata[2]) m_poll = 1;
            if (bus_wdata[1]) m_rsel = bus_wdata[0];
            if (bus_wdata[6]) m_smm = bus_wdata[5];
         end else if (bus_wr && !bus_addr) begin
            code = int'(bus_wdata[7:5]);
            ln = int'(bus_wdata[2:0]);
            case (code)
               0, 4: m_raeoi = bus_wdata[7];
               1, 5: begin
                  r = rank_of(m_isr, m_rb);
                  if (r < 8) begin
                     ln = (m_rb + r) % 8;
                     clr_i[ln] = 1; m_eoiv = 1; m_eoid = ln;
                     if (code == 5) begin m_rb = (ln + 1) % 8; base_cmd = 1; end
                  end
               end
               3: begin clr_i[ln] = 1; m_eoiv = 1; m_eoid = ln; end
               6: begin m_rb = (ln + 1) % 8; base_cmd = 1; end
               7: begin clr_i[ln] = 1; m_eoiv = 1; m_eoid = ln; m_rb = (ln + 1) % 8; base_cmd = 1; end
               default: ;
            endcase
         end else if (bus_wr) begin
            case (m_ph)
               0: m_imr = bus_wdata;
               1: begin m_vec = bus_wdata & 8'hF8; m_ph = 2; end
               2: m_ph = m_need4 ? 3 : 0;
               default: begin m_nest = bus_wdata[4]; m_aeoi = bus_wdata[1]; m_ph = 0; end
            endcase
         end else if (bus_rd && m_poll) begin
            logic [7:0] pb;
            pb = m_poll_byte();
            m_poll = 0;
            if (pb[7]) begin
               ln = int'(pb[2:0]);
               clr_i[ln] = 1; clr_r[ln] = 1; m_eoiv = 1; m_eoid = ln;
            end
         end
         if (grant_vld) begin
            if (!lvl_mode[grant_id]) clr_r[grant_id] = 1;
            if (o_aeoi) begin
               if (o_raeoi && !init && !base_cmd) m_rb = (int'(grant_id) + 1) % 8;
            end else set_i[grant_id] = 1;
         end
         for (int i = 0; i < 8; i++) begin
            if (lvl_mode[i]) m_irr[i] = irq_in[i];
            else if (init) m_irr[i] = 0;
            else m_irr[i] = (m_irr[i] & ~clr_r[i]) | (irq_in[i] & ~m_prev[i]);
         end
         m_prev = init ? 8'h00 : irq_in;
         m_isr = (m_isr & ~clr_i) | set_i;
      end
   end

   // every-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         if (!rst_n) begin
            chk("R1", "reset irr|isr|imr", {8'h0, irr_o, isr_o, imr_o}, 32'h0);
            chk("R1", "reset flags", {auto_eoi, nested_mode, poll_armed, init_busy, eoi_vld}, 0);
         end else begin
            chk("R9", "irr", irr_o, m_irr);
            chk("R10", "isr", isr_o, m_isr);
            chk("R5", "imr", imr_o, m_imr);
            chk("R3", "vec_base", vec_base, m_vec);
            chk("R3", "init_busy", init_busy, m_ph != 0);
            chk("R4", "nested_mode", nested_mode, m_nest);
            chk("R4", "auto_eoi", auto_eoi, m_aeoi);
            chk("R8", "rot_base", rot_base, m_rb);
            chk("R8", "rot_on_aeoi", rot_on_aeoi, m_raeoi);
            chk("R6", "special_mask", special_mask, m_smm);
            chk("R6", "read_isr", read_isr, m_rsel);
            chk("R6", "poll_armed", poll_armed, m_poll);
            chk(m_poll ? "R11" : "R12", "bus_rdata", bus_rdata, m_rdata());
            chk("R13", "eoi_vld", eoi_vld, m_eoiv);
            if (m_eoiv) chk("R13", "eoi_id", eoi_id, m_eoid);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic op(input bit w, input bit r, input bit a, input logic [7:0] d,
                     input bit g, input logic [2:0] gid);
      @(posedge clk);
      #2;
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; grant_vld = g; grant_id = gid;
   endtask
   task automatic wr(input bit a, input logic [7:0] d); op(1, 0, a, d, 0, 0); endtask
   task automatic rd(input bit a);                      op(0, 1, a, 0, 0, 0); endtask
   task automatic gnt(input logic [2:0] id);            op(0, 0, 0, 0, 1, id); endtask
   task automatic idle();                               op(0, 0, 0, 0, 0, 0); endtask
   // step so that the previous op is registered and sample mid-cycle
   task automatic look(); idle(); @(negedge clk); endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog expired actual=hung expected=finished");
         done = 1;
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
      grant_vld = 0; grant_id = 0; irq_in = 0; lvl_mode = 0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      chk("R1", "first cycle imr", imr_o, 8'h00);

      // configuration with options word
      wr(0, 8'h11); look();
      chk("R2", "imr after start", imr_o, 8'h00);
      chk("R2", "busy after start", init_busy, 1);
      wr(1, 8'h4D); wr(1, 8'hFF); wr(1, 8'h12); look();
      chk("R3", "vec_base masked", vec_base, 8'h48);
      chk("R3", "imr kept during sequence", imr_o, 8'h00);
      chk("R4", "nested and aeoi", {nested_mode, auto_eoi}, 2'b11);
      wr(1, 8'hF0); look();
      chk("R5", "imr load", imr_o, 8'hF0);

      // requests, aeoi grants and rotation on aeoi
      lvl_mode = 8'h20; irq_in = 8'h2A;
      idle(); idle();
      wr(0, 8'h0A); rd(0);
      gnt(1);
      wr(0, 8'h80);
      gnt(3); look();
      chk("R10", "aeoi grant leaves isr", isr_o, 8'h00);
      chk("R10", "aeoi rotation", rot_base, 3'd4);

      // restart, options word needed so aeoi stays until word 4
      wr(0, 8'h11); look();
      chk("R2", "aeoi kept when options word expected", auto_eoi, 1);
      wr(1, 8'h40); wr(1, 8'h00); wr(1, 8'h00); look();
      chk("R4", "options cleared", {nested_mode, auto_eoi}, 2'b00);

      irq_in = 8'h00; lvl_mode = 8'h00; idle();
      irq_in = 8'h0F; idle(); idle();
      gnt(0); gnt(2); gnt(3); look();
      chk("R10", "isr after grants", isr_o, 8'h0D);
      wr(0, 8'h0B); rd(0); rd(1);
      wr(0, 8'h20); look();
      chk("R7", "ns eoi isr", isr_o, 8'h0C);
      chk("R13", "ns eoi report", {eoi_vld, eoi_id}, {1'b1, 3'd0});
      wr(0, 8'hA0); look();
      chk("R8", "rotating eoi base", rot_base, 3'd3);
      chk("R8", "rotating eoi isr", isr_o, 8'h08);
      wr(0, 8'h63); look();
      chk("R8", "specific eoi", isr_o, 8'h00);
      wr(0, 8'h20); look();
      chk("R7", "empty ns eoi isr", isr_o, 8'h00);
      chk("R7", "empty ns eoi no report", eoi_vld, 0);
      wr(0, 8'hC5); look();
      chk("R8", "priority set", rot_base, 3'd6);
      wr(0, 8'hE1); wr(0, 8'h40); look();
      chk("R8", "code 7 then code 2", rot_base, 3'd2);
      wr(0, 8'h68);

      // poll reads
      irq_in = 8'h00; idle();
      irq_in = 8'h50; idle(); idle();
      wr(0, 8'h0C); rd(0); look();
      chk("R11", "poll retires line", irr_o & 8'h10, 8'h00);
      chk("R11", "poll disarmed", poll_armed, 0);
      rd(0);
      wr(0, 8'h0C); rd(1);
      wr(0, 8'h0C); rd(0);
      wr(0, 8'h0C); op(1, 1, 1, 8'h55, 0, 0); look();
      chk("R12", "write wins over read", poll_armed, 1);
      rd(0);

      // grant and specific eoi of the same line in one cycle
      op(1, 0, 0, 8'h64, 1, 3'd4); look();
      chk("R14", "set wins on same bit", isr_o[4], 1);
      chk("R14", "eoi still reported", {eoi_vld, eoi_id}, {1'b1, 3'd4});

      // start without options word clears aeoi
      wr(0, 8'h11); wr(1, 0); wr(1, 0); wr(1, 8'h02);
      wr(0, 8'h10); look();
      chk("R2", "aeoi cleared without options word", auto_eoi, 0);
      wr(1, 0); wr(1, 0); look();
      chk("R3", "sequence ends after word 3", init_busy, 0);

      // random mix checked against the model every cycle
      for (int n = 0; n < 4000; n++) begin
         logic [7:0] d;
         bit w, r, g;
         d = 8'($urandom);
         w = ($urandom % 4) == 0;
         r = ($urandom % 4) == 0;
         g = ($urandom % 6) == 0;
         if (w && !d[0] && d[4] && ($urandom % 3) != 0) d[4] = 0;
         if (($urandom % 3) == 0) irq_in = irq_in ^ 8'(1 << ($urandom % 8));
         if (($urandom % 200) == 0) lvl_mode = 8'($urandom);
         op(w, r, 1'($urandom), d, g, 3'($urandom));
      end
      look();
      done = 1;
      summary();
      $finish;
   end
endmodule